// File: doc/BRIEF.md
# Multiprocessor Shared Bus Arbiter

This block decides who owns a single shared external bus. Up to six processor nodes and one external host can ask for it. Each node has its own active-low request line, selected by its ID, and every node can see all the other lines. A static select input chooses between fixed priority and rotating priority among the nodes. The host request outranks every node. Once the host is granted, it keeps the bus until it withdraws its request.

A node normally hands the bus on only when its current transfer has finished, which the master-done input signals. Two things can force an earlier change of ownership: a host request, and a core-priority request that lets a waiting node cut into background DMA traffic. One dead cycle separates any two masters. During that cycle no grant is active and the bus is floated, so two drivers never overlap. A suspend input floats the bus from the next cycle on and freezes ownership until it is released.

The state machine has four states:
- IDLE: nobody owns the bus.
- NODE: a node owns the bus.
- GAP: the dead cycle between two masters.
- HOST: the host owns the bus.

The transitions are:
- IDLE to NODE on a node request.
- IDLE to HOST on a host request.
- NODE to GAP on a host request, on a core-priority pre-emption, or on done when a different node wins.
- NODE to IDLE on done when nobody is requesting.
- GAP to HOST on a host request.
- GAP to NODE on a node request.
- GAP to IDLE when there are no requests.
- HOST to GAP when the host releases its request.

Top module: `mp_bus_arbiter`

## Requirements
- R1: While reset is active, and after it, `grant` is all zero, `host_grant` is 0 and `bus_en` is 0. The rotation pointer starts at the highest node, so node index 0 ranks first under rotation.
- R2: Bit i of `req_n` belongs to node index i, and 0 means requesting. A line held at 1 (unused) is never granted. With `rot_sel`=0, the lowest requesting index wins. From IDLE, the grant appears one cycle after the request is sampled.
- R3: With `rot_sel`=1, the search starts at the index just above the last owner and wraps around, so the last owner ranks lowest.
- R4: A node keeps the bus until `xfer_done` is sampled high, unless a pre-emption occurs. If at done the arbitration picks the same owner again, the grant stays unchanged. If nobody requests at done, the block goes to IDLE in the next cycle.
- R5: Between two different masters (node to node, node to host, or host to node), exactly one cycle passes with `grant`=0, `host_grant`=0 and `bus_en`=0.
- R6: `host_req_n`=0 outranks every node request. In IDLE or GAP it is granted at the next edge. During node ownership it forces GAP at the next edge, without waiting for done or the end of suspend.
- R7: `host_grant` stays at 1 for as long as `host_req_n` is sampled low. After release, one GAP cycle follows.
- R8: If `core_pri_n`=0 is sampled while a node owns the bus and some other node is requesting, ownership moves without done. The GAP cycle that follows excludes the old owner from arbitration. If no other node requests, `core_pri_n` has no effect.
- R9: `suspend_n`=0 sampled at an edge drives `bus_en` to 0 from that edge onward, and `bus_en` returns one edge after release. At an edge where suspend is sampled, both `xfer_done` and `core_pri_n` are ignored and the owner keeps `grant`.
- R10: `grant` is one-hot or zero. It is never active together with `host_grant`. `bus_en` is 1 only while a node holds a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | NODES | Node requests, active low, bit i = node index i |
| host_req_n | input | 1 | Host request, active low |
| rot_sel | input | 1 | 1 = rotating priority, 0 = fixed priority |
| core_pri_n | input | 1 | Core-priority pre-emption, active low |
| xfer_done | input | 1 | Current master's transaction ends at this edge |
| suspend_n | input | 1 | Bus suspend, active low |
| grant | output | NODES | One-hot node grant |
| host_grant | output | 1 | Host owns the bus |
| bus_en | output | 1 | Enable for the owning node's bus drivers |

## Verification
Two functions can fall in the same cycle here. One pair is suspend with done or core-priority: a node's done or core-priority request can arrive in the very cycle that suspend is sampled. The other pair is a host request arriving on top of a frozen suspended owner. The directed phases drive these pairs on the same edge. The randomized phase toggles all the inputs independently so that they collide often. A behavioural model in the bench predicts the owner, the dead cycle and the bus enable on every clock. The bench judges that suspend wins over done and core-priority, while the host still pre-empts.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NODE = 2'd1,
        ST_GAP  = 2'd2,
        ST_HOST = 2'd3
    } arb_state_e;
endpackage

// File: rtl/arb_picker.sv
module arb_picker #(
    parameter int NODES = 6,
    parameter int IW    = $clog2(NODES)
) (
    input  logic [NODES-1:0] req,
    input  logic [IW-1:0]    last,
    input  logic             rotate,
    output logic             any,
    output logic [IW-1:0]    win
);
    function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] a, input int off);
        int s;
        s = int'(a) + off;
        if (s >= NODES) s = s - NODES;
        return s[IW-1:0];
    endfunction

    always_comb begin
        any = |req;
        win = '0;
        if (rotate) begin
            // scan downward so the nearest index above last ends up winning
            for (int off = NODES; off >= 1; off--) begin
                if (req[wrap_add(last, off)]) win = wrap_add(last, off);
            end
        end else begin
            for (int i = NODES - 1; i >= 0; i--) begin
                if (req[i]) win = IW'(i);
            end
        end
    end
endmodule

// File: rtl/arb_outdec.sv
module arb_outdec
    import arb_pkg::*;
#(
    parameter int NODES = 6,
    parameter int IW    = $clog2(NODES)
) (
    input  arb_state_e       state,
    input  logic [IW-1:0]    owner,
    input  logic             susp_q,
    output logic [NODES-1:0] grant,
    output logic             host_grant,
    output logic             bus_en
);
    always_comb begin
        grant      = '0;
        host_grant = 1'b0;
        bus_en     = 1'b0;
        unique case (state)
            ST_NODE: begin
                grant  = NODES'(1) << owner;
                bus_en = !susp_q;
            end
            ST_HOST: host_grant = 1'b1;
            ST_IDLE, ST_GAP: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/mp_bus_arbiter.sv
module mp_bus_arbiter
    import arb_pkg::*;
#(
    parameter int NODES = 6,
    localparam int IW   = $clog2(NODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NODES-1:0] req_n,
    input  logic             host_req_n,
    input  logic             rot_sel,
    input  logic             core_pri_n,
    input  logic             xfer_done,
    input  logic             suspend_n,
    output logic [NODES-1:0] grant,
    output logic             host_grant,
    output logic             bus_en
);
    arb_state_e    state, nstate;
    logic [IW-1:0] owner, nowner;
    logic          excl, nexcl;
    logic          susp_q;

    logic [NODES-1:0] reqs, own_oh, reqs_x;
    logic             all_any, x_any, sel_any;
    logic [IW-1:0]    all_win, x_win, sel_win;
    logic             host_req, core_req, susp_now;

    assign reqs     = ~req_n;
    assign own_oh   = NODES'(1) << owner;
    assign reqs_x   = reqs & ~own_oh;
    assign host_req = !host_req_n;
    assign core_req = !core_pri_n;
    assign susp_now = !suspend_n;

    arb_picker #(.NODES(NODES), .IW(IW)) u_pick_all (
        .req(reqs), .last(owner), .rotate(rot_sel), .any(all_any), .win(all_win)
    );
    arb_picker #(.NODES(NODES), .IW(IW)) u_pick_excl (
        .req(reqs_x), .last(owner), .rotate(rot_sel), .any(x_any), .win(x_win)
    );

    assign sel_any = excl ? x_any : all_any;
    assign sel_win = excl ? x_win : all_win;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            owner  <= IW'(NODES - 1);
            excl   <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            state  <= nstate;
            owner  <= nowner;
            excl   <= nexcl;
            susp_q <= susp_now;
        end
    end

    // transitions
    always_comb begin
        nstate = state;
        nowner = owner;
        nexcl  = excl;
        unique case (state)
            ST_IDLE: begin
                if (host_req) begin
                    nstate = ST_HOST;
                end else if (all_any) begin
                    nstate = ST_NODE;
                    nowner = all_win;
                end
            end
            ST_NODE: begin
                if (host_req) begin
                    nstate = ST_GAP;
                    nexcl  = 1'b0;
                end else if (!susp_now) begin
                    if (core_req && x_any) begin
                        nstate = ST_GAP;
                        nexcl  = 1'b1;
                    end else if (xfer_done) begin
                        if (!all_any) begin
                            nstate = ST_IDLE;
                        end else if (all_win != owner) begin
                            nstate = ST_GAP;
                            nexcl  = 1'b0;
                        end
                    end
                end
            end
            ST_GAP: begin
                nexcl = 1'b0;
                if (host_req) begin
                    nstate = ST_HOST;
                end else if (sel_any) begin
                    nstate = ST_NODE;
                    nowner = sel_win;
                end else begin
                    nstate = ST_IDLE;
                end
            end
            ST_HOST: begin
                if (!host_req) begin
                    nstate = ST_GAP;
                    nexcl  = 1'b0;
                end
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // outputs
    arb_outdec #(.NODES(NODES), .IW(IW)) u_outdec (
        .state(state), .owner(owner), .susp_q(susp_q),
        .grant(grant), .host_grant(host_grant), .bus_en(bus_en)
    );

    assert_grant_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && !(host_grant && (|grant)));
    assert_bus_en_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> (|grant));
    assert_node_dead_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> (!host_grant && (grant == '0 || grant == $past(grant))));
    assert_host_dead_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_grant |=> (grant == '0));
    assert_host_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_grant && !host_req_n) |=> host_grant);
    assert_suspend_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !suspend_n |=> !bus_en);
endmodule

// File: tb/test_mp_bus_arbiter.sv
`timescale 1ns/1ps
module test_mp_bus_arbiter;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] req_n;
    logic         host_req_n, rot_sel, core_pri_n, xfer_done, suspend_n;
    logic [N-1:0] grant;
    logic         host_grant, bus_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state: 0 idle, 1 node, 2 gap, 3 host
    int m_state, m_own, m_susp;
    bit m_excl;

    always #5 clk = ~clk;

    mp_bus_arbiter #(.NODES(N)) i_mp_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .host_req_n(host_req_n),
        .rot_sel(rot_sel), .core_pri_n(core_pri_n), .xfer_done(xfer_done),
        .suspend_n(suspend_n), .grant(grant), .host_grant(host_grant), .bus_en(bus_en)
    );

    function automatic int mpick(input logic [N-1:0] r, input int last, input bit rot);
        int k;
        if (!rot) begin
            for (int i = 0; i < N; i++) if (r[i]) return i;
            return -1;
        end
        k = last;
        repeat (N) begin
            k = (k + 1) % N;
            if (r[k]) return k;
        end
        return -1;
    endfunction

    task automatic model_step();
        logic [N-1:0] r, rx;
        bit h, c, s;
        int p;
        if (!rst_n) begin
            m_state = 0; m_own = N - 1; m_excl = 0; m_susp = 0;
            return;
        end
        r = ~req_n; h = !host_req_n; c = !core_pri_n; s = !suspend_n;
        rx = r; rx[m_own] = 1'b0;
        case (m_state)
            0: if (h) m_state = 3;
               else if (r != 0) begin m_state = 1; m_own = mpick(r, m_own, rot_sel); end
            1: if (h) begin m_state = 2; m_excl = 0; end
               else if (!s) begin
                   if (c && rx != 0) begin m_state = 2; m_excl = 1; end
                   else if (xfer_done) begin
                       p = mpick(r, m_own, rot_sel);
                       if (p < 0) m_state = 0;
                       else if (p != m_own) begin m_state = 2; m_excl = 0; end
                   end
               end
            2: begin
                p = mpick(m_excl ? rx : r, m_own, rot_sel);
                m_excl = 0;
                if (h) m_state = 3;
                else if (p >= 0) begin m_state = 1; m_own = p; end
                else m_state = 0;
            end
            default: if (!h) begin m_state = 2; m_excl = 0; end
        endcase
        m_susp = s;
    endtask

    task automatic cyc(input string tag);
        logic [N-1:0] eg;
        bit eh, eb;
        @(posedge clk);
        model_step();
        #1;
        eg = (m_state == 1) ? (N'(1) << m_own) : '0;
        eh = (m_state == 3);
        eb = (m_state == 1) && !m_susp;
        checks++;
        if (grant !== eg || host_grant !== eh || bus_en !== eb) begin
            errors++;
            $display("FAIL %s grant=%b/%b host_grant=%b/%b bus_en=%b/%b (actual/expected)",
                     tag, grant, eg, host_grant, eh, bus_en, eb);
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        req_n = '1; host_req_n = 1; core_pri_n = 1; xfer_done = 0; suspend_n = 1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 0; rot_sel = 0; idle_inputs();
        @(negedge clk);
        // R1: reset state
        req_n = 6'b000000; host_req_n = 0;
        repeat (3) cyc("R1");
        idle_inputs(); rst_n = 1;
        cyc("R1");

        // R2: fixed priority, indices 3 and 5 request
        rot_sel = 0; req_n = ~6'b101000;
        cyc("R2"); cyc("R2");
        xfer_done = 1; cyc("R2");          // owner 3 wins again, kept
        req_n = ~6'b100000; cyc("R2");     // done, 5 wins -> gap
        xfer_done = 0; cyc("R5"); cyc("R2");
        req_n = ~6'b000011; xfer_done = 1; cyc("R2"); cyc("R2");
        xfer_done = 0; cyc("R2");

        // R4: no done, others wait; then done with no requests
        req_n = ~6'b000101; repeat (3) cyc("R4");
        req_n = '1; xfer_done = 1; cyc("R4"); xfer_done = 0; cyc("R4"); cyc("R4");

        // R3: rotating priority, all request, done every cycle
        rot_sel = 1; req_n = '0; cyc("R3");
        xfer_done = 1; repeat (14) cyc("R3");
        xfer_done = 0; req_n = ~6'b010001; repeat (2) cyc("R3");
        xfer_done = 1; repeat (6) cyc("R3"); xfer_done = 0;

        // R6 / R7: host over node ownership and held
        req_n = ~6'b000110; rot_sel = 0; cyc("R6");
        host_req_n = 0; repeat (2) cyc("R6");
        xfer_done = 1; core_pri_n = 0; repeat (4) cyc("R7");
        xfer_done = 0; core_pri_n = 1; host_req_n = 1; repeat (3) cyc("R7");

        // R8: core priority pre-emption
        req_n = ~6'b000011; cyc("R8");
        core_pri_n = 0; cyc("R8"); cyc("R8"); cyc("R8");
        req_n = ~6'b000010; repeat (2) cyc("R8");
        core_pri_n = 1; req_n = ~6'b000001; xfer_done = 1; repeat (3) cyc("R8");
        xfer_done = 0; req_n = ~6'b000001; core_pri_n = 0; repeat (2) cyc("R8"); // only owner
        core_pri_n = 1;

        // R9: suspend with done and core priority on the same edge, then host
        req_n = ~6'b000011; cyc("R9");
        suspend_n = 0; xfer_done = 1; core_pri_n = 0; repeat (3) cyc("R9");
        core_pri_n = 1; xfer_done = 0; suspend_n = 1; cyc("R9");
        suspend_n = 0; host_req_n = 0; repeat (3) cyc("R9");
        host_req_n = 1; suspend_n = 1; repeat (3) cyc("R9");

        // R10: randomized collisions
        for (int n = 0; n < 4000; n++) begin
            req_n      = N'($urandom);
            host_req_n = ($urandom % 8) != 0;
            rot_sel    = (n / 500) % 2;
            core_pri_n = ($urandom % 6) != 0;
            xfer_done  = ($urandom % 3) == 0;
            suspend_n  = ($urandom % 7) != 0;
            cyc("R10");
        end
        summary();
    end
endmodule